// File: doc/BRIEF.md
# Two-Slot Static Issue Gate

This block sits at the issue point of a statically scheduled, two-wide, in-order pipeline. Each cycle it may receive one 64-bit fetch packet that holds two 32-bit instructions. Slot 0 is the instruction at the lower address (bits 31:0) and may hold only an arithmetic or branch operation. Slot 1 is the instruction at address plus 4 (bits 63:32) and may hold only a load or a store. Either slot may instead hold a no-op. Both slots then move through the later stages in lockstep.

The block decodes the instruction class and register fields of both slots. It rejects packets that break the slot typing. It holds a packet for one cycle when a load issued in the previous cycle produces a register that the packet reads. When the memory slot reads the arithmetic slot's result from the same packet, it splits the pair over two cycles. Its outputs say which slots issue in the current cycle and why the packet is held, if it is.

The packet input is a valid/ready stream. `pkt_ready` is high whenever the block consumes the presented packet in this cycle. While `pkt_valid` is high and `pkt_ready` is low, the source must keep `pkt_valid` high and `pkt_data` unchanged. Every decision is combinational on the presented packet and the block's own state, so the issue flags belong to the cycle in which the packet is presented.

Top module: `dual_issue_gate`

## Requirements
- R1: Each instruction has its class in bits [31:28] (0 no-op, 1 arithmetic, 2 branch, 3 load, 4 store; 5 to 15 undefined), destination in [27:23], first source in [22:18] and second source in [17:13]. Arithmetic writes the destination and reads both sources. Branch reads both sources and writes nothing. Load reads the first source and writes the destination. Store reads both sources (base, data). Slot 0 is `pkt_data[31:0]` and slot 1 is `pkt_data[63:32]`.
- R2: If slot 0 holds a class other than no-op, arithmetic or branch, or slot 1 holds a class other than no-op, load or store, then `illegal` is high, neither slot issues and the packet is consumed. This check takes priority over every hazard check.
- R3: A legal packet with no hazard is consumed in one cycle. Each non-no-op slot raises its issue flag in that cycle. At most one of `stall`, `split` and `illegal` is high in any cycle.
- R4: A no-op slot never issues and never causes a stall or a split, whatever its register fields hold.
- R5: If slot 0 writes a register that slot 1 reads, the packet is split. In the first cycle only slot 0 issues, `split` is high and `pkt_ready` is low. In the next cycle with `pkt_valid` high, only slot 1 issues, slot 0 is a bubble and the packet is consumed.
- R6: If the load issued in the previous cycle writes a register that either slot of the presented packet reads, `stall` is high for exactly one cycle, nothing issues and `pkt_ready` is low. The packet is then handled as if no load were in flight.
- R7: Register 0 never creates a dependency, either inside a packet or against an in-flight load.
- R8: A branch in slot 0 never causes a split. The result of an arithmetic instruction issued in one cycle is usable by the next packet without a stall.
- R9: After reset no load is in flight and no split is pending. With `pkt_valid` low all flags are low and `pkt_ready` is high.
- R10: A cycle with `pkt_valid` low issues nothing, and it retires any in-flight load, so the packet that follows sees no load hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | A fetch packet is presented |
| pkt_data | input | 64 | Packet: slot 0 in [31:0], slot 1 in [63:32] |
| pkt_ready | output | 1 | The presented packet is consumed in this cycle |
| issue0_valid | output | 1 | Slot 0 issues in this cycle |
| issue1_valid | output | 1 | Slot 1 issues in this cycle |
| stall | output | 1 | Packet held because of an in-flight load |
| split | output | 1 | First half of a split packet: slot 0 issues alone |
| illegal | output | 1 | Slot typing violated; packet dropped |

## Verification
The in-RTL assertions check these rules on every cycle: the hold flags are mutually exclusive, a stall never lasts two cycles, the cycle after a split never issues slot 0, an illegal packet issues nothing and is consumed, an idle cycle issues nothing, and a register-0 destination never produces a hazard. Only the bench scenarios can show that the right flag appears for a given register pattern. These include split versus no split for base and data sources, a stall caused by either slot, no-op slots whose fields are ignored, branches that write nothing, a stall followed by a split, and an idle cycle that clears the load hazard.

// File: rtl/dig_pkg.sv
package dig_pkg;
  localparam int INSN_W = 32;
  localparam int CLS_W  = 4;
  localparam int REG_W  = 5;
  localparam int CLS_LSB = INSN_W - CLS_W;
  localparam int DST_LSB = CLS_LSB - REG_W;
  localparam int SA_LSB  = DST_LSB - REG_W;
  localparam int SB_LSB  = SA_LSB - REG_W;
  localparam int SLOTS   = 2;

  typedef enum logic [CLS_W-1:0] {
    K_NOP = 4'd0,
    K_ALU = 4'd1,
    K_BR  = 4'd2,
    K_LD  = 4'd3,
    K_ST  = 4'd4
  } kind_e;

  typedef struct packed {
    logic             nop;
    logic             legal;
    logic             is_ld;
    logic             wr;
    logic [REG_W-1:0] dst;
    logic             use_a;
    logic             use_b;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
  } slot_info_t;

  function automatic logic reads_reg(slot_info_t s, logic [REG_W-1:0] r);
    return (s.use_a && s.src_a == r) || (s.use_b && s.src_b == r);
  endfunction
endpackage

// File: rtl/dig_slot_decode.sv
module dig_slot_decode
  import dig_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [INSN_W-1:0] insn,
  output slot_info_t        info
);
  logic [CLS_W-1:0] cls;
  logic [REG_W-1:0] rd, ra, rb;
  logic             mem_slot;

  assign cls = insn[CLS_LSB +: CLS_W];
  assign rd  = insn[DST_LSB +: REG_W];
  assign ra  = insn[SA_LSB  +: REG_W];
  assign rb  = insn[SB_LSB  +: REG_W];
  assign mem_slot = (SLOT != 0);

  always_comb begin
    info       = '0;
    info.dst   = rd;
    info.src_a = ra;
    info.src_b = rb;
    case (cls)
      K_NOP: begin
        info.nop   = 1'b1;
        info.legal = 1'b1;
      end
      K_ALU: begin
        info.legal = !mem_slot;
        info.wr    = (rd != '0);
        info.use_a = (ra != '0);
        info.use_b = (rb != '0);
      end
      K_BR: begin
        info.legal = !mem_slot;
        info.use_a = (ra != '0);
        info.use_b = (rb != '0);
      end
      K_LD: begin
        info.legal = mem_slot;
        info.is_ld = 1'b1;
        info.wr    = (rd != '0);
        info.use_a = (ra != '0);
      end
      K_ST: begin
        info.legal = mem_slot;
        info.use_a = (ra != '0);
        info.use_b = (rb != '0);
      end
      default: info.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dig_hazard.sv
module dig_hazard
  import dig_pkg::*;
(
  input  slot_info_t       info0,
  input  slot_info_t       info1,
  input  logic             ld_live,
  input  logic [REG_W-1:0] ld_dst,
  output logic             load_hit,
  output logic             pair_dep
);
  assign load_hit = ld_live && (reads_reg(info0, ld_dst) || reads_reg(info1, ld_dst));
  assign pair_dep = info0.wr && reads_reg(info1, info0.dst);
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import dig_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  input  logic [SLOTS*INSN_W-1:0] pkt_data,
  output logic                    pkt_ready,
  output logic                    issue0_valid,
  output logic                    issue1_valid,
  output logic                    stall,
  output logic                    split,
  output logic                    illegal
);
  slot_info_t       info [SLOTS];
  logic             load_hit, pair_dep, bad_type;
  logic             second_half;
  logic             ld_live;
  logic [REG_W-1:0] ld_dst;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    dig_slot_decode #(.SLOT(s)) u_dec (
      .insn (pkt_data[s*INSN_W +: INSN_W]),
      .info (info[s])
    );
  end

  dig_hazard u_haz (
    .info0    (info[0]),
    .info1    (info[1]),
    .ld_live  (ld_live),
    .ld_dst   (ld_dst),
    .load_hit (load_hit),
    .pair_dep (pair_dep)
  );

  assign bad_type = !(info[0].legal && info[1].legal);

  always_comb begin
    pkt_ready    = 1'b1;
    issue0_valid = 1'b0;
    issue1_valid = 1'b0;
    stall        = 1'b0;
    split        = 1'b0;
    illegal      = 1'b0;
    if (pkt_valid) begin
      if (second_half) begin
        issue1_valid = !info[1].nop;
      end else if (bad_type) begin
        illegal = 1'b1;
      end else if (load_hit) begin
        stall     = 1'b1;
        pkt_ready = 1'b0;
      end else if (pair_dep) begin
        split        = 1'b1;
        issue0_valid = 1'b1;
        pkt_ready    = 1'b0;
      end else begin
        issue0_valid = !info[0].nop;
        issue1_valid = !info[1].nop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      ld_live     <= 1'b0;
      ld_dst      <= '0;
    end else begin
      if (split)
        second_half <= 1'b1;
      else if (pkt_valid)
        second_half <= 1'b0;
      ld_live <= issue1_valid && info[1].is_ld && info[1].wr;
      ld_dst  <= info[1].dst;
    end
  end

  a_r3_one_reason: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, split, illegal}));

  a_r2_illegal_drops: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!issue0_valid && !issue1_valid && pkt_ready));

  a_r6_stall_once: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r5_bubble_after_split: assert property (@(posedge clk) disable iff (!rst_n)
    split |=> (!issue0_valid && !split));

  a_r7_zero_no_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pair_dep |-> (info[0].dst != '0));

  a_r7_zero_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |-> (ld_dst != '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!issue0_valid && !issue1_valid && pkt_ready));
endmodule

// File: tb/sim_dual_issue_gate.sv
module sim_dual_issue_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_data = '0;
  logic        pkt_ready, issue0_valid, issue1_valid, stall, split, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  dual_issue_gate u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .issue0_valid(issue0_valid), .issue1_valid(issue1_valid),
    .stall(stall), .split(split), .illegal(illegal)
  );

  // R1 field layout: class, dest, src a, src b, zero pad
  function automatic logic [31:0] ins(int cls, int rd, int ra, int rb);
    return {cls[3:0], rd[4:0], ra[4:0], rb[4:0], 13'd0};
  endfunction

  // one cycle: drive packet and push the expected flags {i0,i1,rdy,stall,split,ill}
  task automatic cyc(input bit v, input logic [31:0] s0, input logic [31:0] s1,
                     input logic [5:0] exp, input string tag);
    @(posedge clk);
    #1;
    pkt_valid = v;
    pkt_data  = {s1, s0};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compare combinational flags mid-cycle
  always @(negedge clk) begin
    if (tag_q.size() > 0) begin
      logic [5:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {issue0_valid, issue1_valid, pkt_ready, stall, split, illegal};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: got i0,i1,rdy,stall,split,ill=%b expected %b", t, a, e);
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  localparam logic [31:0] NOP = 32'd0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state: idle outputs
    cyc(0, NOP, NOP, 6'b001000, "R9 idle after reset");
    // R3 independent pair issues together
    cyc(1, ins(1,1,2,3), ins(3,4,5,0), 6'b111000, "R3 alu+load");
    // R6 negative: load r4 in flight, packet does not read r4
    cyc(1, ins(1,6,7,8), ins(4,0,9,10), 6'b111000, "R6 no match");
    // R6 slot 0 reads load dest
    cyc(1, NOP, ins(3,4,5,0), 6'b011000, "R4 nop slot0 load");
    cyc(1, ins(1,6,4,1), NOP, 6'b000100, "R6 stall slot0");
    cyc(1, ins(1,6,4,1), NOP, 6'b101000, "R6 after stall");
    // R6 slot 1 store base reads load dest
    cyc(1, NOP, ins(3,7,2,0), 6'b011000, "R6 load r7");
    cyc(1, NOP, ins(4,0,7,3), 6'b000100, "R6 stall slot1");
    cyc(1, NOP, ins(4,0,7,3), 6'b011000, "R6 slot1 after stall");
    // R5 split on load base
    cyc(1, ins(1,8,1,2), ins(3,9,8,0), 6'b100010, "R5 split first");
    cyc(1, ins(1,8,1,2), ins(3,9,8,0), 6'b011000, "R5 split second");
    // R5 split on store data (load r9 in flight but not read)
    cyc(1, ins(1,11,1,2), ins(4,0,1,11), 6'b100010, "R5 store data split");
    cyc(1, ins(1,11,1,2), ins(4,0,1,11), 6'b011000, "R5 store data second");
    // R7 register 0 inside pair
    cyc(1, ins(1,0,1,2), ins(3,3,0,0), 6'b111000, "R7 pair r0");
    // R7 load to r0 then reader of r0
    cyc(1, NOP, ins(3,0,1,0), 6'b011000, "R7 load r0");
    cyc(1, ins(1,5,0,0), NOP, 6'b101000, "R7 no stall on r0");
    // R2 illegal typing
    cyc(1, ins(3,1,2,0), NOP, 6'b001001, "R2 load in slot0");
    cyc(1, NOP, ins(1,1,2,3), 6'b001001, "R2 alu in slot1");
    cyc(1, ins(7,1,2,3), NOP, 6'b001001, "R2 undefined class");
    // R2 priority over load hazard
    cyc(1, NOP, ins(3,12,1,0), 6'b011000, "R2 load r12");
    cyc(1, ins(1,1,12,0), ins(2,0,12,0), 6'b001001, "R2 illegal beats stall");
    // R4 no-op fields ignored for split and stall
    cyc(1, ins(0,5,5,5), ins(3,6,5,0), 6'b011000, "R4 nop no split");
    cyc(1, ins(0,6,6,6), ins(4,0,1,2), 6'b011000, "R4 nop no stall");
    // R8 branch writes nothing; alu result usable next packet
    cyc(1, ins(2,3,1,2), ins(3,4,3,0), 6'b111000, "R8 branch no split");
    cyc(1, ins(1,12,1,2), NOP, 6'b101000, "R8 alu r12");
    cyc(1, ins(1,13,12,12), ins(4,0,12,1), 6'b111000, "R8 alu chain no stall");
    // R10 idle cycle retires load
    cyc(1, NOP, ins(3,13,1,0), 6'b011000, "R10 load r13");
    cyc(0, ins(1,1,13,0), NOP, 6'b001000, "R10 idle");
    cyc(1, ins(1,1,13,0), NOP, 6'b101000, "R10 no stall after idle");
    // R6 then R5: stall followed by split
    cyc(1, NOP, ins(3,4,1,0), 6'b011000, "R6 load r4 again");
    cyc(1, ins(1,5,4,1), ins(4,0,2,5), 6'b000100, "R6 stall before split");
    cyc(1, ins(1,5,4,1), ins(4,0,2,5), 6'b100010, "R5 split after stall");
    cyc(1, ins(1,5,4,1), ins(4,0,2,5), 6'b011000, "R5 second after stall");
    cyc(0, NOP, NOP, 6'b001000, "R3 final idle");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule